// File: doc/BRIEF.md
# Level and Single-Edge Trigger Matcher

This block watches a stream of 16-channel logic samples and signals when a programmed trigger condition is met. A channel can be left out, or it can demand a steady low, a steady high, a rising edge or a falling edge. All participating channels must agree on the same sample for the trigger to fire. An edge is judged between two consecutive valid samples, so cycles without the valid strobe do not count.

The condition is set by four 32-bit configuration words: a channel-in-use mask, a participation enable mask, a level-or-edge select mask and a polarity mask. Only the low 16 bits of each word are used. A configuration that asks for edges on more than one channel is rejected. The block raises an error flag and blocks the trigger until the configuration is corrected.

The matcher comes out of reset armed. It fires a single one-cycle pulse, then stays quiet until `arm_i` re-arms it. Re-arming also discards the stored edge history.

Top module: `trig_match`

## Requirements
- R1: A channel takes part only when both its in-use bit and its enable bit are 1. Bits 31..16 of all four configuration words have no effect.
- R2: With its level-select bit set to 1, a participating channel matches low when its polarity bit is 0 and high when its polarity bit is 1.
- R3: With its level-select bit set to 0, a participating channel matches a 0-to-1 change when its polarity bit is 0 and a 1-to-0 change when its polarity bit is 1. The change is taken between the previous and the current valid sample. The first valid sample after arming never matches an edge.
- R4: The trigger condition holds only when every participating channel matches on the same valid sample.
- R5: When no channel takes part, the first valid sample after arming fires the trigger.
- R6: When more than one participating channel is in edge mode, `cfg_err_o` is 1 one cycle later and no trigger is produced. When the configuration is valid, `cfg_err_o` is 0.
- R7: `trig_o` is high for exactly one cycle, in the cycle after the qualifying valid sample. The block then disarms and ignores further samples. Samples presented without `smp_valid_i` are neither evaluated nor stored as edge history.
- R8: `arm_i` re-arms the block and clears the edge history. A sample presented in the same cycle as `arm_i` is neither evaluated nor stored.
- R9: After reset, `trig_o` and `cfg_err_o` are 0 and the block is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_inuse_i | input | 32 | Channel-in-use mask |
| cfg_en_i | input | 32 | Participation enable mask |
| cfg_lvl_i | input | 32 | 1 = level, 0 = edge, per channel |
| cfg_pol_i | input | 32 | 1 = high/falling, 0 = low/rising |
| arm_i | input | 1 | Re-arm and clear edge history |
| smp_i | input | 16 | Sample vector |
| smp_valid_i | input | 1 | Sample strobe |
| trig_o | output | 1 | One-cycle trigger pulse |
| cfg_err_o | output | 1 | More than one edge channel configured |

## Verification
The hardest state to reach from the ports is an edge decision that depends on history the bench cannot see directly. Examples are a rising edge that spans idle cycles, or a stored previous sample that re-arming must discard. The bench reaches these states with deliberate sequences. In one, a low valid sample is followed by a high value presented without the strobe and then a high valid sample, which must fire. In another, a low sample is followed by a re-arm and then a high sample, which must not fire until a further low-to-high pair arrives. A separate sequence applies a rising edge on two edge channels at once and shows that the error flag blocks the trigger.

// File: rtl/trig_pkg.sv
package trig_pkg;
    // Number of sample channels and width of a configuration word.
    localparam int unsigned CH_N   = 16;
    localparam int unsigned WORD_W = 32;
endpackage

// File: rtl/trig_cfg_decode.sv
// Turns the four configuration words into per-channel level and edge masks
// and flags an edge request on more than one channel.
// Assumes the configuration is held static while a capture is armed.
module trig_cfg_decode #(
    parameter int unsigned NCH  = 16,
    parameter int unsigned WW   = 32
) (
    input  logic [WW-1:0]  inuse_i,
    input  logic [WW-1:0]  en_i,
    input  logic [WW-1:0]  lvl_i,
    input  logic [WW-1:0]  pol_i,
    output logic [NCH-1:0] part_o,
    output logic [NCH-1:0] lvl_o,
    output logic [NCH-1:0] pol_o,
    output logic           bad_o
);
    localparam int unsigned CW = $clog2(NCH + 1);

    logic [CW-1:0] edge_cnt;

    // Participation and mode masks from the low channel bits only.
    always_comb begin
        part_o = inuse_i[NCH-1:0] & en_i[NCH-1:0];
        lvl_o  = lvl_i[NCH-1:0];
        pol_o  = pol_i[NCH-1:0];
    end

    // Count the participating channels in edge mode.
    always_comb begin
        edge_cnt = '0;
        for (int i = 0; i < NCH; i++)
            edge_cnt = edge_cnt + CW'(part_o[i] & ~lvl_o[i]);
        bad_o = (edge_cnt > CW'(1));
    end
endmodule

// File: rtl/trig_edge_track.sv
// Remembers the last valid sample so edges can be judged between
// consecutive valid samples. Arming clears the history.
module trig_edge_track #(
    parameter int unsigned NCH = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr_i,
    input  logic           valid_i,
    input  logic [NCH-1:0] smp_i,
    output logic [NCH-1:0] prev_o,
    output logic           prev_ok_o
);
    // Capture history on every valid sample not masked by a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_o    <= '0;
            prev_ok_o <= 1'b0;
        end else if (clr_i) begin
            prev_ok_o <= 1'b0;
        end else if (valid_i) begin
            prev_o    <= smp_i;
            prev_ok_o <= 1'b1;
        end
    end

    // R8: history is gone the cycle after a clear.
    a_r8_clear_history: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !prev_ok_o);
    // R7: history only changes on a valid sample.
    a_r7_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_i && !clr_i) |=> $stable(prev_o));
endmodule

// File: rtl/trig_chan_eval.sv
// Evaluates every channel against its mode and ANDs the results.
// A non-participating channel always agrees.
module trig_chan_eval #(
    parameter int unsigned NCH = 16
) (
    input  logic [NCH-1:0] part_i,
    input  logic [NCH-1:0] lvl_i,
    input  logic [NCH-1:0] pol_i,
    input  logic [NCH-1:0] cur_i,
    input  logic [NCH-1:0] prev_i,
    input  logic           prev_ok_i,
    output logic           all_o
);
    logic [NCH-1:0] ok;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic lvl_hit, edge_hit;
        // Per-channel level and edge comparison.
        always_comb begin
            lvl_hit  = (cur_i[g] == pol_i[g]);
            edge_hit = prev_ok_i & (pol_i[g] ? (prev_i[g] & ~cur_i[g])
                                             : (~prev_i[g] & cur_i[g]));
            ok[g]    = ~part_i[g] | (lvl_i[g] ? lvl_hit : edge_hit);
        end
    end

    // Combine all channel verdicts.
    always_comb all_o = &ok;
endmodule

// File: rtl/trig_match.sv
// Single-stage level and single-edge trigger matcher for a 16-channel
// sample stream. Fires one pulse per arming. Assumes configuration words
// are stable while armed; only the low channel bits are decoded.
module trig_match
    import trig_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] cfg_inuse_i,
    input  logic [WORD_W-1:0] cfg_en_i,
    input  logic [WORD_W-1:0] cfg_lvl_i,
    input  logic [WORD_W-1:0] cfg_pol_i,
    input  logic              arm_i,
    input  logic [CH_N-1:0]   smp_i,
    input  logic              smp_valid_i,
    output logic              trig_o,
    output logic              cfg_err_o
);
    logic [CH_N-1:0] part, lvl, pol, prev;
    logic            bad, prev_ok, all_ok, armed, fire;

    trig_cfg_decode #(.NCH(CH_N), .WW(WORD_W)) u_dec (
        .inuse_i(cfg_inuse_i), .en_i(cfg_en_i), .lvl_i(cfg_lvl_i),
        .pol_i(cfg_pol_i), .part_o(part), .lvl_o(lvl), .pol_o(pol),
        .bad_o(bad)
    );

    trig_edge_track #(.NCH(CH_N)) u_hist (
        .clk(clk), .rst_n(rst_n), .clr_i(arm_i), .valid_i(smp_valid_i),
        .smp_i(smp_i), .prev_o(prev), .prev_ok_o(prev_ok)
    );

    trig_chan_eval #(.NCH(CH_N)) u_eval (
        .part_i(part), .lvl_i(lvl), .pol_i(pol), .cur_i(smp_i),
        .prev_i(prev), .prev_ok_i(prev_ok), .all_o(all_ok)
    );

    // Qualifying sample: armed, strobed, not masked by arm, valid config.
    always_comb fire = armed & smp_valid_i & ~arm_i & all_ok & ~bad;

    // Arming state, pulse and error registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed     <= 1'b1;
            trig_o    <= 1'b0;
            cfg_err_o <= 1'b0;
        end else begin
            trig_o    <= fire;
            cfg_err_o <= bad;
            if (arm_i)     armed <= 1'b1;
            else if (fire) armed <= 1'b0;
        end
    end

    // R7: pulse lasts one cycle.
    a_r7_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o |=> !trig_o);
    // R7: a pulse follows a strobed sample.
    a_r7_after_valid: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o |-> $past(smp_valid_i));
    // R6: a rejected configuration never coincides with a pulse.
    a_r6_err_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err_o |-> !trig_o);
    // R8: a sample in the arming cycle is not evaluated.
    a_r8_arm_masks: assert property (@(posedge clk) disable iff (!rst_n)
        arm_i |=> !trig_o);
    // R7: block disarms after firing unless re-armed.
    a_r7_disarm: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_o && !$past(arm_i) && !arm_i) |-> !fire);
endmodule

// File: tb/sim_trig_match.sv
module sim_trig_match;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] inuse = 32'hFFFF, en = '0, lvl = '0, pol = '0;
    logic        arm = 1'b0, vld = 1'b0;
    logic [15:0] smp = '0;
    logic        trig, err;
    int          n_chk = 0, n_bad = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    trig_match u0 (
        .clk(clk), .rst_n(rst_n), .cfg_inuse_i(inuse), .cfg_en_i(en),
        .cfg_lvl_i(lvl), .cfg_pol_i(pol), .arm_i(arm), .smp_i(smp),
        .smp_valid_i(vld), .trig_o(trig), .cfg_err_o(err)
    );

    task automatic check(input string req, input logic got, input logic exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b", req, got, exp);
        end
    endtask

    // One strobed (or unstrobed) sample; returns trig_o one cycle later.
    task automatic step(input logic [15:0] s, input logic v, output logic t);
        @(negedge clk); smp = s; vld = v;
        @(posedge clk); #1; t = trig; vld = 1'b0;
    endtask

    task automatic rearm(input logic [15:0] s, input logic v, output logic t);
        @(negedge clk); arm = 1'b1; smp = s; vld = v;
        @(posedge clk); #1; t = trig; arm = 1'b0; vld = 1'b0;
    endtask

    task automatic setcfg(input logic [31:0] u, e, l, p);
        @(negedge clk); inuse = u; en = e; lvl = l; pol = p;
        @(posedge clk); #1;
    endtask

    task automatic t_reset;
        check("R9 trig after reset", trig, 1'b0);
        check("R9 err after reset", err, 1'b0);
    endtask

    task automatic t_none;
        logic t;
        setcfg(32'hFFFF, 32'h0, 32'h0, 32'h0);
        step(16'h1234, 1'b1, t); check("R5 fire on first sample", t, 1'b1);
        step(16'h1234, 1'b1, t); check("R7 single pulse then disarmed", t, 1'b0);
    endtask

    task automatic t_level;
        logic t;
        setcfg(32'hFFFF, 32'h0008, 32'h0008, 32'h0008);
        rearm(16'h0, 1'b0, t);
        step(16'h0000, 1'b1, t); check("R2 high not met", t, 1'b0);
        step(16'h0008, 1'b1, t); check("R2 high met", t, 1'b1);
        setcfg(32'hFFFF, 32'h0020, 32'h0020, 32'h0000);
        rearm(16'h0, 1'b0, t);
        step(16'h0020, 1'b1, t); check("R2 low not met", t, 1'b0);
        step(16'h0000, 1'b1, t); check("R2 low met", t, 1'b1);
    endtask

    task automatic t_edge;
        logic t;
        setcfg(32'hFFFF, 32'h0004, 32'h0000, 32'h0000);
        rearm(16'h0, 1'b0, t);
        step(16'h0004, 1'b1, t); check("R3 no edge on first sample", t, 1'b0);
        step(16'h0000, 1'b1, t); check("R3 falling ignored in rise mode", t, 1'b0);
        step(16'h0004, 1'b1, t); check("R3 rising met", t, 1'b1);
        setcfg(32'hFFFF, 32'h0080, 32'h0000, 32'h0080);
        rearm(16'h0, 1'b0, t);
        step(16'h0080, 1'b1, t); check("R3 fall first sample", t, 1'b0);
        step(16'h0000, 1'b1, t); check("R3 falling met", t, 1'b1);
    endtask

    task automatic t_and;
        logic t;
        setcfg(32'hFFFF, 32'h0013, 32'h0003, 32'h0003);
        rearm(16'h0, 1'b0, t);
        step(16'h0001, 1'b1, t); check("R4 prep", t, 1'b0);
        step(16'h0011, 1'b1, t); check("R4 edge but ch1 low", t, 1'b0);
        step(16'h0003, 1'b1, t); check("R4 levels but no edge", t, 1'b0);
        step(16'h0013, 1'b1, t); check("R4 all agree", t, 1'b1);
    endtask

    task automatic t_mask;
        logic t;
        setcfg(32'hFDFF, 32'h0200, 32'h0200, 32'h0200);
        rearm(16'h0, 1'b0, t);
        step(16'h0000, 1'b1, t); check("R1 unused channel excluded", t, 1'b1);
        setcfg(32'hFFFF, 32'h0030_0008, 32'h0000_0008, 32'h0000_0008);
        check("R1 upper bits no error", err, 1'b0);
        rearm(16'h0, 1'b0, t);
        step(16'h0008, 1'b1, t); check("R1 upper bits ignored", t, 1'b1);
    endtask

    task automatic t_err;
        logic t;
        setcfg(32'hFFFF, 32'h0006, 32'h0000, 32'h0000);
        check("R6 error flagged", err, 1'b1);
        rearm(16'h0, 1'b0, t);
        step(16'h0000, 1'b1, t);
        step(16'h0006, 1'b1, t); check("R6 no trigger when invalid", t, 1'b0);
        setcfg(32'hFFFF, 32'h0006, 32'h0002, 32'h0002);
        check("R6 error clears", err, 1'b0);
    endtask

    task automatic t_arm_hist;
        logic t;
        setcfg(32'hFFFF, 32'h0004, 32'h0000, 32'h0000);
        rearm(16'h0, 1'b0, t);
        step(16'h0000, 1'b1, t);
        rearm(16'h0004, 1'b1, t); check("R8 sample with arm ignored", t, 1'b0);
        step(16'h0004, 1'b1, t); check("R8 history cleared", t, 1'b0);
        step(16'h0000, 1'b1, t);
        step(16'h0004, 1'b1, t); check("R8 edge after rearm", t, 1'b1);
        setcfg(32'hFFFF, 32'h0000, 32'h0000, 32'h0000);
        rearm(16'h0, 1'b1, t); check("R8 arm masks level sample", t, 1'b0);
    endtask

    task automatic t_idle;
        logic t;
        setcfg(32'hFFFF, 32'h0004, 32'h0000, 32'h0000);
        rearm(16'h0, 1'b0, t);
        step(16'h0000, 1'b1, t);
        step(16'h0004, 1'b0, t); check("R7 unstrobed not evaluated", t, 1'b0);
        step(16'h0000, 1'b0, t);
        step(16'h0004, 1'b1, t); check("R7 edge across idle cycles", t, 1'b1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_none();
        t_level();
        t_edge();
        t_and();
        t_mask();
        t_err();
        t_arm_hist();
        t_idle();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule